// File: doc/BRIEF.md
# Dual-Range Pulse Peak Finder

This block measures the charge of one photomultiplier channel from two ADC sample streams that watch the same shaped pulse. One stream comes through a high-gain amplifier and resolves small pulses finely. The other comes through a low-gain amplifier and covers large pulses coarsely. The two charge ranges overlap. Both streams deliver one 12-bit sample per clock, which is one sample every 25 ns at 40 MSPS.

A start flag opens a search window of programmable length. Only pulses that raise the flag are measured. During the window the block tracks the largest sample on each path and records the position of that sample. When the window closes, it checks whether the high-gain peak is saturated by comparing it with a threshold. It then reports either the high-gain peak or the low-gain peak. The reported peak has a baseline subtracted and is clamped at zero. The charge word also carries a range flag and the sample index of the peak. It is qualified by a one-cycle valid strobe, ready for a per-channel buffer.

Top module: `dual_range_peak_finder`

## Requirements
- R1: After a synchronous active-low reset, `meas_valid_o` is 0 and `meas_range_o`, `meas_peak_o` and `meas_index_o` are all 0.
- R2: A window opens when `start_i` is 1 and no window is open. The sample presented in that same cycle is sample index 0. The window spans `win_len_i` consecutive samples, and a `win_len_i` of 0 is treated as 1. Samples outside the window have no effect on the result.
- R3: A `start_i` pulse that arrives while a window is open is ignored. That window keeps its length and produces exactly one result.
- R4: On each path the block keeps the largest sample in the window and its index. When several samples equal the maximum, the earliest index is kept.
- R5: If the raw high-gain peak is greater than or equal to `sat_level_i`, the result uses the low-gain peak and index with `meas_range_o` = 1. Otherwise it uses the high-gain peak and index with `meas_range_o` = 0.
- R6: `meas_peak_o` equals the selected raw peak minus `baseline_i`, or 0 when the baseline is greater than or equal to that peak.
- R7: If a window opens at clock edge k with length L, `meas_valid_o` is 1 for exactly the one cycle that follows edge k+L. A new window can open at edge k+L, so consecutive measurements need no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Hit/start flag that opens a window |
| hi_sample_i | input | 12 | High-gain (fine range) ADC sample |
| lo_sample_i | input | 12 | Low-gain (coarse range) ADC sample |
| win_len_i | input | 6 | Window length in samples (0 acts as 1) |
| baseline_i | input | 12 | Baseline subtracted from the reported peak |
| sat_level_i | input | 12 | High-gain saturation threshold |
| meas_valid_o | output | 1 | One-cycle strobe for the result |
| meas_range_o | output | 1 | 1 = low-gain peak reported, 0 = high-gain |
| meas_peak_o | output | 12 | Baseline-corrected peak, clamped at zero |
| meas_index_o | output | 6 | Sample index of the reported peak |

## Verification
The main function is tested with triangular pulses placed at the start, the middle and the last sample of windows of length 1 to 32. Full-scale samples are driven just before and just after each window, so any leak outside the window changes the result. The thresholds are set below, equal to and above the high-gain peak, which separates the two range choices and the boundary case of equality. The baseline is set below and above the peak to show the subtraction and the clamp. Directed cases cover the rest. A flat pulse checks that ties keep the earliest index. A length of zero checks the minimum window. A second start inside a window checks that it is ignored. A start on the closing edge checks back-to-back measurements.

// File: rtl/dpf_pkg.sv
// Package: shared widths and the result word of the dual-range peak finder.
// Assumes one sample per clock on each path.
package dpf_pkg;
    localparam int SAMPLE_W = 12;
    localparam int LEN_W    = 6;

    typedef struct packed {
        logic                low_range;
        logic [SAMPLE_W-1:0] peak;
        logic [LEN_W-1:0]    index;
    } charge_word_t;
endpackage

// File: rtl/dpf_window_ctrl.sv
// Window sequencer: opens a search window on a start flag when idle,
// numbers the samples inside it and flags the last one. Starts that
// arrive while a window is open are dropped.
// Assumes win_len_i is held stable while a window is open.
module dpf_window_ctrl #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] win_len_i,
    output logic             load_o,
    output logic             track_o,
    output logic [LEN_W-1:0] index_o,
    output logic             done_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic             busy_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] eff_len;
    logic             last;

    // Length 0 is treated as a single-sample window.
    always_comb begin
        eff_len = (win_len_i == '0) ? ONE : win_len_i;
        load_o  = start_i && !busy_q;
        track_o = busy_q;
        index_o = busy_q ? cnt_q : '0;
        last    = (load_o && eff_len == ONE) || (busy_q && cnt_q == eff_len - ONE);
    end

    // Window state and sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (load_o) begin
            busy_q <= (eff_len != ONE);
            cnt_q  <= ONE;
        end else if (busy_q) begin
            busy_q <= !last;
            cnt_q  <= last ? '0 : cnt_q + ONE;
        end
    end

    // Close strobe, one cycle after the last sample has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= last;
    end

    // R2
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < eff_len));

    // R3
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/dpf_peak_tracker.sv
// Peak tracker for one gain path: loads the first sample of a window and
// replaces the running maximum only on a strictly larger sample, so ties
// keep the earliest index.
// Assumes load_i and track_i are never both set.
module dpf_peak_tracker #(
    parameter int SAMPLE_W = 12,
    parameter int LEN_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                track_i,
    input  logic [LEN_W-1:0]    index_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [SAMPLE_W-1:0] max_o,
    output logic [LEN_W-1:0]    max_index_o
);
    // Running maximum and its position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_o       <= '0;
            max_index_o <= '0;
        end else if (load_i) begin
            max_o       <= sample_i;
            max_index_o <= '0;
        end else if (track_i && sample_i > max_o) begin
            max_o       <= sample_i;
            max_index_o <= index_i;
        end
    end

    // R4
    max_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        track_i |=> (max_o >= $past(max_o)));
endmodule

// File: rtl/dpf_range_select.sv
// Output stage: picks the gain path by high-gain saturation, subtracts
// the baseline with a clamp at zero, and registers the result word with
// a one-cycle valid.
// Assumes the peak inputs are final in the cycle done_i is high.
module dpf_range_select
    import dpf_pkg::*;
#(
    parameter int SW = SAMPLE_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic [SW-1:0] hi_max_i,
    input  logic [LW-1:0] hi_index_i,
    input  logic [SW-1:0] lo_max_i,
    input  logic [LW-1:0] lo_index_i,
    input  logic [SW-1:0] baseline_i,
    input  logic [SW-1:0] sat_level_i,
    output logic          valid_o,
    output charge_word_t  word_o
);
    logic          use_low;
    logic [SW-1:0] raw_peak;
    logic [LW-1:0] raw_index;
    charge_word_t  next_word;

    // Range choice and baseline correction.
    always_comb begin
        use_low   = (hi_max_i >= sat_level_i);
        raw_peak  = use_low ? lo_max_i : hi_max_i;
        raw_index = use_low ? lo_index_i : hi_index_i;
        next_word.low_range = use_low;
        next_word.peak      = (raw_peak > baseline_i) ? raw_peak - baseline_i : '0;
        next_word.index     = raw_index;
    end

    // Result register and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            word_o  <= '0;
        end else begin
            valid_o <= done_i;
            if (done_i) word_o <= next_word;
        end
    end

    // R5
    high_range_unsat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !word_o.low_range) |-> ($past(hi_max_i) < $past(sat_level_i)));
endmodule

// File: rtl/dual_range_peak_finder.sv
// Top: dual-gain peak finder for one photomultiplier channel. A window
// sequencer drives two peak trackers (high and low gain); the output
// stage chooses the range and emits one charge word per window.
// Assumes configuration inputs are stable while a window is open.
module dual_range_peak_finder
    import dpf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SAMPLE_W-1:0] hi_sample_i,
    input  logic [SAMPLE_W-1:0] lo_sample_i,
    input  logic [LEN_W-1:0]    win_len_i,
    input  logic [SAMPLE_W-1:0] baseline_i,
    input  logic [SAMPLE_W-1:0] sat_level_i,
    output logic                meas_valid_o,
    output logic                meas_range_o,
    output logic [SAMPLE_W-1:0] meas_peak_o,
    output logic [LEN_W-1:0]    meas_index_o
);
    localparam int NPATH = 2;

    logic                load, track, done;
    logic [LEN_W-1:0]    win_index;
    logic [SAMPLE_W-1:0] path_sample [NPATH];
    logic [SAMPLE_W-1:0] path_max    [NPATH];
    logic [LEN_W-1:0]    path_index  [NPATH];
    charge_word_t        word;

    // Path 0 is high gain, path 1 is low gain.
    always_comb begin
        path_sample[0] = hi_sample_i;
        path_sample[1] = lo_sample_i;
    end

    dpf_window_ctrl #(.LEN_W(LEN_W)) win_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .win_len_i(win_len_i),
        .load_o(load), .track_o(track), .index_o(win_index), .done_o(done)
    );

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        dpf_peak_tracker #(.SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W)) trk_i (
            .clk(clk), .rst_n(rst_n), .load_i(load), .track_i(track),
            .index_i(win_index), .sample_i(path_sample[p]),
            .max_o(path_max[p]), .max_index_o(path_index[p])
        );
    end

    dpf_range_select sel_i (
        .clk(clk), .rst_n(rst_n), .done_i(done),
        .hi_max_i(path_max[0]), .hi_index_i(path_index[0]),
        .lo_max_i(path_max[1]), .lo_index_i(path_index[1]),
        .baseline_i(baseline_i), .sat_level_i(sat_level_i),
        .valid_o(meas_valid_o), .word_o(word)
    );

    // Unpack the result word onto the ports.
    always_comb begin
        meas_range_o = word.low_range;
        meas_peak_o  = word.peak;
        meas_index_o = word.index;
    end

    // R7
    valid_follows_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid_o |-> $past(done));
endmodule

// File: tb/dual_range_peak_finder_tb_top.sv
module dual_range_peak_finder_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [11:0] hi_sample_i = '0, lo_sample_i = '0;
    logic [5:0]  win_len_i = 6'd8;
    logic [11:0] baseline_i = '0, sat_level_i = 12'd4095;
    logic meas_valid_o, meas_range_o;
    logic [11:0] meas_peak_o;
    logic [5:0]  meas_index_o;

    int checks = 0, failures = 0, valid_count = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dual_range_peak_finder dut_i (.*);

    always @(posedge clk) if (rst_n && meas_valid_o) valid_count++;

    typedef struct packed {
        logic [5:0] len; logic [5:0] pos;
        logic [11:0] hi; logic [11:0] lo; logic [11:0] base; logic [11:0] thr;
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{6'd8,  6'd3,  12'd1000, 12'd40,   12'd100, 12'd4000},
        '{6'd8,  6'd5,  12'd4095, 12'd2000, 12'd100, 12'd4000},
        '{6'd16, 6'd15, 12'd3000, 12'd120,  12'd0,   12'd3000},
        '{6'd4,  6'd0,  12'd50,   12'd3,    12'd80,  12'd4000},
        '{6'd32, 6'd20, 12'd2999, 12'd150,  12'd10,  12'd3000},
        '{6'd1,  6'd0,  12'd700,  12'd30,   12'd0,   12'd4095}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] smp(logic [11:0] pk, int pos, int i, bit flat);
        int d;
        d = (i > pos ? i - pos : pos - i) * 16;
        if (flat) return pk;
        return (pk > d) ? 12'(pk - d) : 12'd0;
    endfunction

    // One measurement: full-scale before/after the window, optional second start.
    task automatic measure(string req, int len_drv, int len, int pos, logic [11:0] hi,
                           logic [11:0] lo, logic [11:0] base, logic [11:0] thr,
                           bit flat, int mid, logic [11:0] exp_pk, bit exp_rng);
        @(negedge clk);
        win_len_i = 6'(len_drv); baseline_i = base; sat_level_i = thr;
        hi_sample_i = 12'd4095; lo_sample_i = 12'd4095; start_i = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            start_i = (i == 0) || (i == mid);
            hi_sample_i = smp(hi, pos, i, flat);
            lo_sample_i = smp(lo, pos, i, flat);
        end
        @(negedge clk);
        start_i = 1'b0; hi_sample_i = 12'd4095; lo_sample_i = 12'd4095;
        check({req, " R7 no early valid"}, meas_valid_o, 0);
        @(negedge clk);
        check({req, " R7 valid"}, meas_valid_o, 1);
        check({req, " R5 range"}, meas_range_o, exp_rng);
        check({req, " R6 peak"}, meas_peak_o, exp_pk);
        check({req, " R4 index"}, meas_index_o, flat ? 0 : pos);
        @(negedge clk);
        check({req, " R7 one-cycle"}, meas_valid_o, 0);
        hi_sample_i = '0; lo_sample_i = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", meas_valid_o, 0);
        check("R1 range", meas_range_o, 0);
        check("R1 peak", meas_peak_o, 0);
        check("R1 index", meas_index_o, 0);
        rst_n = 1'b1;

        // Vector table (R2, R4, R5, R6)
        for (int v = 0; v < NV; v++) begin
            logic rng;
            logic [11:0] raw;
            rng = VECS[v].hi >= VECS[v].thr;
            raw = rng ? VECS[v].lo : VECS[v].hi;
            measure("R2 table", VECS[v].len, VECS[v].len, VECS[v].pos, VECS[v].hi,
                    VECS[v].lo, VECS[v].base, VECS[v].thr, 1'b0, -1,
                    (raw > VECS[v].base) ? 12'(raw - VECS[v].base) : 12'd0, rng);
        end

        // R2: length zero acts as one sample
        measure("R2 len0", 0, 1, 0, 12'd600, 12'd20, 12'd0, 12'd4095, 1'b0, -1, 12'd600, 1'b0);
        // R4: flat pulse, tie keeps index 0
        measure("R4 tie", 8, 8, 0, 12'd500, 12'd25, 12'd0, 12'd4095, 1'b1, -1, 12'd500, 1'b0);
        // R3: second start inside the window is ignored
        valid_count = 0;
        measure("R3 restart", 8, 8, 6, 12'd800, 12'd30, 12'd0, 12'd4095, 1'b0, 3, 12'd800, 1'b0);
        repeat (10) @(negedge clk);
        check("R3 single result", valid_count, 1);

        // R7: back-to-back windows of length 2
        @(negedge clk);
        win_len_i = 6'd2; baseline_i = '0; sat_level_i = 12'd4095;
        start_i = 1'b1; hi_sample_i = 12'd884; lo_sample_i = 12'd5;
        @(negedge clk);
        start_i = 1'b0; hi_sample_i = 12'd900;
        @(negedge clk);
        start_i = 1'b1; hi_sample_i = 12'd300;
        @(negedge clk);
        start_i = 1'b0; hi_sample_i = 12'd200;
        check("R7 b2b first valid", meas_valid_o, 1);
        check("R7 b2b first peak", meas_peak_o, 900);
        check("R7 b2b first index", meas_index_o, 1);
        @(negedge clk);
        check("R7 b2b gap", meas_valid_o, 0);
        @(negedge clk);
        check("R7 b2b second valid", meas_valid_o, 1);
        check("R7 b2b second peak", meas_peak_o, 300);
        check("R7 b2b second index", meas_index_o, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule